// File: doc/BRIEF.md
# Nonvolatile Write Permission and Cycle Sequencer

This block sits behind the serial bus front-end of a small nonvolatile memory. When the front-end accepts a complete write and sees the STOP, it sends a one-cycle commit pulse. The pulse comes with a target space (the memory array or the control registers), a page number, the page data and a byte mask. A flag on the pulse marks a write that only touches the write enable latch. The block decides whether the commit may go ahead, based on:

- the write enable latch,
- the write-protect pin,
- the protect-enable register bit,
- a signal that says the programming supply is present.

A permitted commit starts the internal programming cycle. During the cycle the block holds `busy_o` high for a number of clock ticks set by a parameter. In the last busy cycle it strobes the captured page into the storage cells. The front-end uses `busy_o` for acknowledge polling: while it is high, no address byte is acknowledged and all traffic is ignored. The front-end also reads `write_permit_o` to decide whether to acknowledge data bytes.

A write to the enable latch never starts a programming cycle. It takes effect on the next clock, so the device is ready again right after the STOP. A commit that fails a permission check is dropped with no sign, and busy stays low.

Top module: `nvw_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it goes high, `wel_o`, `busy_o` and `mem_we_o` are 0. This also holds when reset arrives in the middle of a programming cycle.
- R2: A commit with `commit_latch_i`=1 while idle loads `latch_val_i` into `wel_o` at the next clock edge. It raises no busy period and no strobe, whatever the protect pin, protect bit and supply inputs are.
- R3: `write_permit_o` is 1 exactly when `wel_o`=1, at least one of `wp_pin_i` and `wp_en_i` is 0, and `vpp_ok_i`=1.
- R4: A data commit (`commit_latch_i`=0) while `wel_o`=0 is dropped: no busy period and no strobe.
- R5: A data commit with both `wp_pin_i` and `wp_en_i` high is dropped. With either of them low, the commit proceeds if the other conditions hold.
- R6: A data commit with `vpp_ok_i`=0 is dropped.
- R7: A permitted data commit raises `busy_o` at the clock edge that samples it. `busy_o` then stays high for exactly CYC_LEN cycles.
- R8: `mem_we_o` pulses exactly once per cycle, in the last busy cycle. It carries the space, page, data and mask sampled with the commit, even if the commit inputs change later.
- R9: Every commit that arrives while `busy_o`=1 is ignored. This includes writes to the enable latch. `wel_o` is unchanged, and the cycle is neither extended nor restarted.
- R10: A completed programming cycle leaves `wel_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| commit_i | input | 1 | one-cycle commit pulse from the front-end at STOP |
| commit_latch_i | input | 1 | commit targets the enable latch only |
| latch_val_i | input | 1 | new enable latch value for a latch commit |
| commit_space_i | input | 1 | target space: 0 array, 1 control registers |
| commit_page_i | input | PAGE_AW | page number |
| commit_data_i | input | 8*PAGE_BYTES | page data, byte 0 in bits 7:0 |
| commit_mask_i | input | PAGE_BYTES | per-byte write mask |
| wp_pin_i | input | 1 | write-protect pin level |
| wp_en_i | input | 1 | protect-enable register bit |
| vpp_ok_i | input | 1 | programming supply present |
| wel_o | output | 1 | write enable latch |
| write_permit_o | output | 1 | a data commit would be accepted now |
| busy_o | output | 1 | programming cycle in progress |
| mem_we_o | output | 1 | storage write strobe, one cycle |
| mem_space_o | output | 1 | captured space |
| mem_page_o | output | PAGE_AW | captured page |
| mem_data_o | output | 8*PAGE_BYTES | captured data |
| mem_mask_o | output | PAGE_BYTES | captured mask |

## Verification
The hardest case to reach is a commit that arrives while a cycle is already running. Two things must hold there: a latch-clear commit must not touch the latch, and a second permitted data commit must not stretch or restart the count. The bench starts a permitted cycle and then waits a few cycles. It then fires a latch-clear commit and a fully permitted data commit with different data. It checks three results: the busy length still equals the parameter, exactly one strobe appears carrying the first payload, and the latch still reads 1 afterwards. A reset in the middle of a cycle is reached the same way and checked for a clean return to idle.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic {
    SPC_ARRAY = 1'b0,
    SPC_CTRL  = 1'b1
  } spc_e;
endpackage

// File: rtl/nvw_permit.sv
module nvw_permit (
  input  logic wel_i,
  input  logic wp_pin_i,
  input  logic wp_en_i,
  input  logic vpp_ok_i,
  output logic permit_o
);
  logic prot_relaxed;
  assign prot_relaxed = ~(wp_pin_i & wp_en_i);
  assign permit_o     = wel_i & prot_relaxed & vpp_ok_i;
endmodule

// File: rtl/nvw_latch.sv
module nvw_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic val_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wel_o <= 1'b0;
    else if (wr_i) wel_o <= val_i;
  end
endmodule

// File: rtl/nvw_timer.sv
module nvw_timer #(
  parameter int unsigned CYC_LEN = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(CYC_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == LAST) busy_o <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign last_o = busy_o & (cnt_q == LAST);
endmodule

// File: rtl/nvw_hold.sv
module nvw_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned PAGE_AW    = 4,
  parameter int unsigned CYC_LEN    = 1250000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic                    commit_latch_i,
  input  logic                    latch_val_i,
  input  logic                    commit_space_i,
  input  logic [PAGE_AW-1:0]      commit_page_i,
  input  logic [8*PAGE_BYTES-1:0] commit_data_i,
  input  logic [PAGE_BYTES-1:0]   commit_mask_i,
  input  logic                    wp_pin_i,
  input  logic                    wp_en_i,
  input  logic                    vpp_ok_i,
  output logic                    wel_o,
  output logic                    write_permit_o,
  output logic                    busy_o,
  output logic                    mem_we_o,
  output logic                    mem_space_o,
  output logic [PAGE_AW-1:0]      mem_page_o,
  output logic [8*PAGE_BYTES-1:0] mem_data_o,
  output logic [PAGE_BYTES-1:0]   mem_mask_o
);
  import nvw_pkg::*;

  localparam int unsigned DW = 8 * PAGE_BYTES;
  localparam int unsigned HW = 1 + PAGE_AW + DW + PAGE_BYTES;

  logic permit, start, latch_wr, idle_commit;
  spc_e space_in;

  assign space_in    = spc_e'(commit_space_i);
  assign idle_commit = commit_i & ~busy_o;
  assign latch_wr    = idle_commit & commit_latch_i;
  assign start       = idle_commit & ~commit_latch_i & permit;

  nvw_permit i_permit (
    .wel_i    (wel_o),
    .wp_pin_i (wp_pin_i),
    .wp_en_i  (wp_en_i),
    .vpp_ok_i (vpp_ok_i),
    .permit_o (permit)
  );

  nvw_latch i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (latch_wr),
    .val_i  (latch_val_i),
    .wel_o  (wel_o)
  );

  nvw_timer #(.CYC_LEN(CYC_LEN)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy_o),
    .last_o  (mem_we_o)
  );

  // payload captured with the accepted commit
  logic [HW-1:0] hold_d, hold_q;
  assign hold_d = {space_in, commit_page_i, commit_data_i, commit_mask_i};

  nvw_hold #(.W(HW)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (start),
    .d_i    (hold_d),
    .q_o    (hold_q)
  );

  assign {mem_space_o, mem_page_o, mem_data_o, mem_mask_o} = hold_q;
  assign write_permit_o = permit;
endmodule

// File: rtl/nvw_seq_chk.sv
module nvw_seq_chk #(
  parameter int unsigned CYC_LEN = 1250000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic commit_i,
  input logic commit_latch_i,
  input logic latch_val_i,
  input logic write_permit_o,
  input logic wel_o,
  input logic busy_o,
  input logic mem_we_o
);
  localparam int unsigned CW = $clog2(CYC_LEN + 1) + 1;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bcnt <= '0;
    else if (!busy_o) bcnt <= '0;
    else              bcnt <= bcnt + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> (!busy_o && !wel_o && !mem_we_o));

  // R2
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && commit_latch_i && !busy_o) |=> (wel_o == $past(latch_val_i) && !busy_o));

  // R4
  denied_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !commit_latch_i && !busy_o && !write_permit_o) |=> !busy_o);

  // R7
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i && !commit_latch_i && write_permit_o));

  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt < CW'(CYC_LEN)));

  // R8
  strobe_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (busy_o && bcnt == CW'(CYC_LEN - 1)));

  // R8
  strobe_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !busy_o);

  // R9
  busy_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(wel_o));
endmodule

bind nvw_seq nvw_seq_chk #(.CYC_LEN(CYC_LEN)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .commit_i       (commit_i),
  .commit_latch_i (commit_latch_i),
  .latch_val_i    (latch_val_i),
  .write_permit_o (write_permit_o),
  .wel_o          (wel_o),
  .busy_o         (busy_o),
  .mem_we_o       (mem_we_o)
);

// File: tb/test_nvw_seq.sv
module test_nvw_seq;
  localparam int PB  = 4;
  localparam int AW  = 3;
  localparam int CYC = 8;
  localparam int NV  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic commit = 0, c_latch = 0, l_val = 0, c_space = 0;
  logic [AW-1:0]   c_page = '0;
  logic [8*PB-1:0] c_data = '0;
  logic [PB-1:0]   c_mask = '0;
  logic wp_pin = 0, wp_en = 0, vpp = 0;
  logic wel, permit, busy, mem_we, m_space;
  logic [AW-1:0]   m_page;
  logic [8*PB-1:0] m_data;
  logic [PB-1:0]   m_mask;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  nvw_seq #(.PAGE_BYTES(PB), .PAGE_AW(AW), .CYC_LEN(CYC)) i_nvw_seq (
    .clk_i(clk), .rst_ni(rst_ni), .commit_i(commit), .commit_latch_i(c_latch),
    .latch_val_i(l_val), .commit_space_i(c_space), .commit_page_i(c_page),
    .commit_data_i(c_data), .commit_mask_i(c_mask), .wp_pin_i(wp_pin),
    .wp_en_i(wp_en), .vpp_ok_i(vpp), .wel_o(wel), .write_permit_o(permit),
    .busy_o(busy), .mem_we_o(mem_we), .mem_space_o(m_space), .mem_page_o(m_page),
    .mem_data_o(m_data), .mem_mask_o(m_mask)
  );

  // {latch_val, wp_pin, wp_en, vpp, expect_go}
  localparam logic [4:0] VEC [NV] = '{
    5'b1_0_0_1_1, 5'b1_1_0_1_1, 5'b1_0_1_1_1, 5'b1_1_1_1_0,
    5'b1_0_0_0_0, 5'b0_0_0_1_0, 5'b1_1_0_0_0, 5'b0_1_1_1_0
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic lat, input logic lv, input logic sp,
                       input logic [AW-1:0] pg, input logic [8*PB-1:0] d, input logic [PB-1:0] m);
    @(negedge clk);
    commit = 1; c_latch = lat; l_val = lv; c_space = sp; c_page = pg; c_data = d; c_mask = m;
    @(negedge clk);
    commit = 0; c_latch = 0; c_data = ~d; c_page = ~pg; c_mask = ~m; c_space = ~sp;
  endtask

  // observe from the negedge after the commit edge; returns busy length and strobe count
  task automatic watch(output int len, output int nstb, input logic sp,
                       input logic [AW-1:0] pg, input logic [8*PB-1:0] d, input logic [PB-1:0] m);
    len = 0; nstb = 0;
    while (busy && len < CYC + 4) begin
      if (mem_we) begin
        nstb++;
        chk(len == CYC - 1, "R8 strobe cycle", len, CYC - 1);
        chk(m_space == sp && m_page == pg && m_data == d && m_mask == m,
            "R8 payload", m_data, d);
      end
      len++;
      @(negedge clk);
    end
    if (mem_we) nstb++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int len, nstb;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!wel && !busy && !mem_we, "R1 in reset", {wel, busy, mem_we}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!wel && !busy && !mem_we, "R1 after reset", {wel, busy, mem_we}, 0);

    for (int i = 0; i < NV; i++) begin
      logic lv, go;
      logic [8*PB-1:0] d;
      lv = VEC[i][4]; go = VEC[i][0];
      d  = {4{8'(8'h11 * (i + 1))}};
      wp_pin = 1; wp_en = 1; vpp = 0;  // hostile inputs: latch write must still work (R2)
      issue(1, lv, 0, '0, '0, '0);
      chk(wel == lv && !busy, "R2 latch load", {wel, busy}, {lv, 1'b0});
      wp_pin = VEC[i][3]; wp_en = VEC[i][2]; vpp = VEC[i][1];
      @(negedge clk);
      chk(permit == go, "R3 permit", permit, go);
      issue(0, 0, i[0], AW'(i), d, PB'(i + 1));
      if (go) begin
        chk(busy, "R7 busy start", busy, 1);
        watch(len, nstb, i[0], AW'(i), d, PB'(i + 1));
        chk(len == CYC, "R7 busy length", len, CYC);
        chk(nstb == 1, "R8 one strobe", nstb, 1);
        chk(wel == 1, "R10 latch kept", wel, 1);
      end else begin
        len = 0; nstb = 0;
        repeat (CYC + 2) begin
          if (busy) len++;
          if (mem_we) nstb++;
          @(negedge clk);
        end
        chk(len == 0 && nstb == 0,
            !lv ? "R4 dropped no latch" : (!vpp ? "R6 dropped no supply" : "R5 dropped protected"),
            len + nstb, 0);
      end
    end

    // R9 commits while busy are ignored
    wp_pin = 0; wp_en = 0; vpp = 1;
    issue(1, 1, 0, '0, '0, '0);
    issue(0, 0, 1, 3'd5, 32'hCAFE_F00D, 4'b1010);
    repeat (2) @(negedge clk);
    issue(1, 0, 0, '0, '0, '0);
    issue(0, 0, 0, 3'd2, 32'h1234_5678, 4'b0101);
    chk(wel == 1, "R9 latch untouched", wel, 1);
    len = 0; nstb = 0;
    while (busy && len < CYC + 4) begin
      if (mem_we) begin
        nstb++;
        chk(m_data == 32'hCAFE_F00D && m_page == 3'd5 && m_space == 1 && m_mask == 4'b1010,
            "R9 payload", m_data, 32'hCAFE_F00D);
      end
      len++;
      @(negedge clk);
    end
    chk(len == CYC - 6, "R9 no extension", len, CYC - 6);
    chk(nstb == 1, "R9 one strobe", nstb, 1);

    // R1 reset mid-cycle
    issue(0, 0, 0, 3'd1, 32'hA5A5_A5A5, 4'hF);
    chk(busy, "R7 busy again", busy, 1);
    rst_ni = 0;
    #1;
    chk(!busy && !wel && !mem_we, "R1 mid-cycle reset", {wel, busy, mem_we}, 0);
    @(negedge clk);
    rst_ni = 1;
    repeat (CYC) @(negedge clk);
    chk(!busy && !mem_we, "R1 stays idle", {busy, mem_we}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule